// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block is the control engine of a shadow memory in which every working SRAM byte is paired with a nonvolatile cell. It decides when the whole SRAM is copied into the nonvolatile cells (a store) and when it is copied back (a recall). It also decides when host accesses to the SRAM are allowed.

A store can be started in three ways:
- a software command from the address-sequence decoder;
- an external pull-down on a shared active-low request/busy pin;
- loss of supply, as an automatic store.

A recall is started either by a software command or automatically when the supply returns. The sequencer keeps a flag that records whether the SRAM has been written since the last store or recall, and a volatile automatic-store enable bit. It drives the shared pin low while any store is running.

The cell array and the supply comparator are reduced to handshakes. The array sees a phase code that says which step it must perform. The comparator is a single `pwr_good` level. Every duration is a parameter counted in clock cycles.

The state machine has eight states:
- OFF: supply low, recall pending.
- CLR: SRAM clear step of a recall.
- LD: load step of a recall.
- IDLE: normal access.
- GRACE: accesses may finish after a pin request.
- ERASE: erase step of a store.
- PROG: program step of a store.
- HOLD: waits for the pin to read high.

It makes these transitions:
- OFF→CLR on supply good.
- CLR→LD and LD→IDLE when their counts expire.
- CLR or LD→OFF on supply loss.
- IDLE→ERASE on a software store, or on supply loss when an automatic store is allowed.
- IDLE→OFF on supply loss when it is not.
- IDLE→GRACE on a low pin.
- IDLE→CLR on a software recall.
- GRACE→ERASE or GRACE→HOLD when the grace count expires, depending on the written flag; GRACE also takes the supply-loss exits of IDLE.
- ERASE→PROG on count expiry.
- PROG→HOLD, or PROG→OFF when the supply is gone.
- HOLD→IDLE on a high pin, or HOLD→OFF on supply loss.

Top module: `nvsr_seq`

## Requirements
- R1: After reset the sequencer is in OFF. In OFF, `arr_phase` is 0 (none), `busy_pull` is 0, `wr_grant` and `rd_grant` are 0, `autostore_en` is 1 and `dirty` is 0.
- R2: When `pwr_good` is high in OFF, a power-up recall runs: `arr_phase` 3 (clear) for PUP_RECALL_CYC/2 cycles, then 4 (load) for the remaining cycles, then idle. No access is granted while it runs.
- R3: In idle, `rd_grant` follows a read cycle (`host_ce_n` low, `host_we_n` high). `wr_grant` follows a write cycle (both low) when the pin is high and writes are armed. `dirty` becomes 1 the cycle after a granted write.
- R4: A software command with `sw_cmd_kind` 00 starts a store whatever the state of `dirty`. The store shows phase 1 (erase) for STORE_CYC/2 cycles, then phase 2 (program) for the rest. `busy_pull` is 1 for exactly those cycles.
- R5: A software command with kind 01 starts a recall: phase 3 for SW_RECALL_CYC/2 cycles, then phase 4 for the rest. `busy_pull` stays 0.
- R6: A low pin seen in idle opens a grace window of GRACE_CYC cycles, in which reads are granted and writes are not. After the window a store runs only if `dirty` is 1. Otherwise no store runs and the block waits in HOLD.
- R7: After a pin-started store, or a pin request without a store, writes stay blocked until the pin reads high.
- R8: Loss of supply in idle or grace starts a store only if `autostore_en` and `dirty` are both 1. In every case the block then rests in OFF. No access is granted while `pwr_good` is low or while any phase is active.
- R9: Kind 10 clears `autostore_en` and kind 11 sets it, with no array activity. The bit is saved at each store and restored by each power-up recall, so a change not followed by a store is lost across a supply cycle.
- R10: On each return to idle, a write cycle that is already in progress is held off. Writes are allowed again only after `host_ce_n` or `host_we_n` has gone high and a new write cycle begins.
- R11: Simultaneous triggers are served in this order: supply loss, then the pin, then a software command. Commands that arrive while an operation runs are dropped.
- R12: `dirty` is 0 from the first cycle of every store and every recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply above switch threshold |
| hwreq_n_in | input | 1 | Level read back from the shared active-low request/busy pin |
| busy_pull | output | 1 | Open-drain enable: 1 pulls the shared pin low (store running) |
| sw_cmd_valid | input | 1 | One-cycle command strobe from the sequence decoder |
| sw_cmd_kind | input | 2 | 00 store, 01 recall, 10 autostore off, 11 autostore on |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| wr_grant | output | 1 | Host write allowed into the SRAM this cycle |
| rd_grant | output | 1 | Host read allowed this cycle |
| arr_phase | output | 3 | Array step: 0 none, 1 erase, 2 program, 3 clear, 4 load |
| autostore_en | output | 1 | Volatile automatic-store enable |
| dirty | output | 1 | SRAM written since last store or recall |

## Verification
The assertions rely on three things about the inputs:
- the read-back pin is low whenever `busy_pull` is high, as it is on a real open-drain net;
- a command strobe lasts one cycle;
- every duration parameter is at least two cycles, so each phase really occurs.

The bench models the pin as the wired-AND of its own pull-down and `busy_pull`. It drives all inputs half a cycle away from the clock edge, and its durations are short enough that every phase boundary can be counted exactly.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_CLR,
        ST_LD,
        ST_IDLE,
        ST_GRACE,
        ST_ERASE,
        ST_PROG,
        ST_HOLD
    } nvsr_state_t;

    typedef enum logic [2:0] {
        PH_NONE  = 3'd0,
        PH_ERASE = 3'd1,
        PH_PROG  = 3'd2,
        PH_CLEAR = 3'd3,
        PH_LOAD  = 3'd4
    } nvsr_phase_t;

    localparam logic [1:0] CMD_STORE    = 2'b00;
    localparam logic [1:0] CMD_RECALL   = 2'b01;
    localparam logic [1:0] CMD_AUTO_OFF = 2'b10;
    localparam logic [1:0] CMD_AUTO_ON  = 2'b11;

endpackage

// File: rtl/nvsr_timer.sv
module nvsr_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/nvsr_access_gate.sv
module nvsr_access_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic host_ce_n,
    input  logic host_we_n,
    input  logic in_idle,
    input  logic in_grace,
    input  logic pin_high,
    input  logic pwr_good,
    input  logic rearm,
    output logic wr_grant,
    output logic rd_grant
);
    logic wr_cyc;
    logic armed;

    assign wr_cyc = !host_ce_n && !host_we_n;

    // A write cycle already open when idle is entered is not armed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (rearm) begin
            armed <= !wr_cyc;
        end else if (!wr_cyc) begin
            armed <= 1'b1;
        end
    end

    assign wr_grant = in_idle && pwr_good && pin_high && armed && wr_cyc;
    assign rd_grant = (in_idle || in_grace) && pwr_good && !host_ce_n && host_we_n;

    // R10: a write granted in the first idle cycle must have been absent the cycle before
    assert_rearm_fresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_idle) && wr_cyc && $past(wr_cyc)) |-> !wr_grant);

endmodule

// File: rtl/nvsr_flags.sv
module nvsr_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_grant,
    input  logic store_start,
    input  logic recall_start,
    input  logic pup_start,
    input  logic auto_cmd,
    input  logic auto_val,
    output logic dirty,
    output logic autostore_en
);
    logic nv_auto;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dirty <= 1'b0;
        end else if (store_start || recall_start) begin
            dirty <= 1'b0;
        end else if (wr_grant) begin
            dirty <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            autostore_en <= 1'b1;
            nv_auto      <= 1'b1;
        end else begin
            if (store_start) begin
                nv_auto <= autostore_en;
            end
            if (pup_start) begin
                autostore_en <= nv_auto;
            end else if (auto_cmd) begin
                autostore_en <= auto_val;
            end
        end
    end

    // R3: the written flag only rises after a granted write
    assert_dirty_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dirty) |-> $past(wr_grant));

endmodule

// File: rtl/nvsr_fsm.sv
module nvsr_fsm
    import nvsr_pkg::*;
#(
    parameter int STORE_CYC      = 625000,
    parameter int SW_RECALL_CYC  = 2000,
    parameter int PUP_RECALL_CYC = 1000000,
    parameter int GRACE_CYC      = 50,
    parameter int CW             = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good,
    input  logic          pin_high,
    input  logic          sw_cmd_valid,
    input  logic [1:0]    sw_cmd_kind,
    input  logic          dirty,
    input  logic          autostore_en,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output nvsr_phase_t   phase,
    output logic          busy_pull,
    output logic          in_idle,
    output logic          in_grace,
    output logic          store_start,
    output logic          recall_start,
    output logic          pup_start,
    output logic          rearm,
    output logic          auto_cmd,
    output logic          auto_val
);
    localparam int ERASE_CYC  = STORE_CYC / 2;
    localparam int PROG_CYC   = STORE_CYC - ERASE_CYC;
    localparam int SW_CLR_CYC = SW_RECALL_CYC / 2;
    localparam int SW_LD_CYC  = SW_RECALL_CYC - SW_CLR_CYC;
    localparam int PU_CLR_CYC = PUP_RECALL_CYC / 2;
    localparam int PU_LD_CYC  = PUP_RECALL_CYC - PU_CLR_CYC;

    nvsr_state_t st, nxt;
    logic        rc_pup;
    logic        auto_ok;

    assign auto_ok = autostore_en && dirty;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_OFF;
            rc_pup <= 1'b0;
        end else begin
            st <= nxt;
            if (st == ST_OFF && nxt == ST_CLR) begin
                rc_pup <= 1'b1;
            end else if (st == ST_IDLE && nxt == ST_CLR) begin
                rc_pup <= 1'b0;
            end
        end
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            ST_OFF: begin
                if (pwr_good) nxt = ST_CLR;
            end
            ST_CLR: begin
                if (!pwr_good)    nxt = ST_OFF;
                else if (tmr_zero) nxt = ST_LD;
            end
            ST_LD: begin
                if (!pwr_good)    nxt = ST_OFF;
                else if (tmr_zero) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (!pwr_good)                                    nxt = auto_ok ? ST_ERASE : ST_OFF;
                else if (!pin_high)                               nxt = ST_GRACE;
                else if (sw_cmd_valid && sw_cmd_kind == CMD_STORE)  nxt = ST_ERASE;
                else if (sw_cmd_valid && sw_cmd_kind == CMD_RECALL) nxt = ST_CLR;
            end
            ST_GRACE: begin
                if (!pwr_good)     nxt = auto_ok ? ST_ERASE : ST_OFF;
                else if (tmr_zero) nxt = dirty ? ST_ERASE : ST_HOLD;
            end
            ST_ERASE: begin
                if (tmr_zero) nxt = ST_PROG;
            end
            ST_PROG: begin
                if (tmr_zero) nxt = pwr_good ? ST_HOLD : ST_OFF;
            end
            ST_HOLD: begin
                if (!pwr_good)    nxt = ST_OFF;
                else if (pin_high) nxt = ST_IDLE;
            end
            default: nxt = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        phase     = PH_NONE;
        busy_pull = 1'b0;
        unique case (st)
            ST_ERASE: begin phase = PH_ERASE; busy_pull = 1'b1; end
            ST_PROG:  begin phase = PH_PROG;  busy_pull = 1'b1; end
            ST_CLR:   phase = PH_CLEAR;
            ST_LD:    phase = PH_LOAD;
            default:  phase = PH_NONE;
        endcase

        in_idle      = (st == ST_IDLE);
        in_grace     = (st == ST_GRACE);
        store_start  = (nxt == ST_ERASE) && (st != ST_ERASE);
        recall_start = (nxt == ST_CLR) && (st != ST_CLR);
        pup_start    = (st == ST_OFF) && (nxt == ST_CLR);
        rearm        = (nxt == ST_IDLE) && (st != ST_IDLE);
        auto_cmd     = (st == ST_IDLE) && (nxt == ST_IDLE) && sw_cmd_valid && sw_cmd_kind[1];
        auto_val     = sw_cmd_kind[0];

        tmr_load = (nxt != st);
        unique case (nxt)
            ST_CLR:   tmr_val = (st == ST_OFF) ? CW'(PU_CLR_CYC - 1) : CW'(SW_CLR_CYC - 1);
            ST_LD:    tmr_val = rc_pup ? CW'(PU_LD_CYC - 1) : CW'(SW_LD_CYC - 1);
            ST_GRACE: tmr_val = CW'(GRACE_CYC - 1);
            ST_ERASE: tmr_val = CW'(ERASE_CYC - 1);
            ST_PROG:  tmr_val = CW'(PROG_CYC - 1);
            default:  tmr_val = '0;
        endcase
    end

    // R4: erase is always followed by program
    assert_erase_then_prog_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ERASE) |=> (phase == PH_ERASE || phase == PH_PROG));

    // R4: program is only reached through erase
    assert_prog_after_erase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PROG) |-> ($past(phase) == PH_ERASE || $past(phase) == PH_PROG));

    // R5: load is only reached through clear
    assert_load_after_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOAD) |-> ($past(phase) == PH_CLEAR || $past(phase) == PH_LOAD));

    // R7: while the pin is seen low outside a store, idle is never entered
    assert_hold_until_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && !pin_high) |=> (st != ST_IDLE));

endmodule

// File: rtl/nvsr_seq.sv
module nvsr_seq #(
    parameter int STORE_CYC      = 625000,
    parameter int SW_RECALL_CYC  = 2000,
    parameter int PUP_RECALL_CYC = 1000000,
    parameter int GRACE_CYC      = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic       hwreq_n_in,
    output logic       busy_pull,
    input  logic       sw_cmd_valid,
    input  logic [1:0] sw_cmd_kind,
    input  logic       host_ce_n,
    input  logic       host_we_n,
    output logic       wr_grant,
    output logic       rd_grant,
    output logic [2:0] arr_phase,
    output logic       autostore_en,
    output logic       dirty
);
    import nvsr_pkg::*;

    localparam int MAX_AB = (STORE_CYC > SW_RECALL_CYC) ? STORE_CYC : SW_RECALL_CYC;
    localparam int MAX_CD = (PUP_RECALL_CYC > GRACE_CYC) ? PUP_RECALL_CYC : GRACE_CYC;
    localparam int MAXD   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW     = $clog2(MAXD + 1);

    logic          tmr_load, tmr_zero;
    logic [CW-1:0] tmr_val;
    nvsr_phase_t   phase;
    logic          in_idle, in_grace;
    logic          store_start, recall_start, pup_start, rearm;
    logic          auto_cmd, auto_val;

    nvsr_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    nvsr_fsm #(
        .STORE_CYC      (STORE_CYC),
        .SW_RECALL_CYC  (SW_RECALL_CYC),
        .PUP_RECALL_CYC (PUP_RECALL_CYC),
        .GRACE_CYC      (GRACE_CYC),
        .CW             (CW)
    ) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_good     (pwr_good),
        .pin_high     (hwreq_n_in),
        .sw_cmd_valid (sw_cmd_valid),
        .sw_cmd_kind  (sw_cmd_kind),
        .dirty        (dirty),
        .autostore_en (autostore_en),
        .tmr_zero     (tmr_zero),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .phase        (phase),
        .busy_pull    (busy_pull),
        .in_idle      (in_idle),
        .in_grace     (in_grace),
        .store_start  (store_start),
        .recall_start (recall_start),
        .pup_start    (pup_start),
        .rearm        (rearm),
        .auto_cmd     (auto_cmd),
        .auto_val     (auto_val)
    );

    nvsr_access_gate i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_ce_n (host_ce_n),
        .host_we_n (host_we_n),
        .in_idle   (in_idle),
        .in_grace  (in_grace),
        .pin_high  (hwreq_n_in),
        .pwr_good  (pwr_good),
        .rearm     (rearm),
        .wr_grant  (wr_grant),
        .rd_grant  (rd_grant)
    );

    nvsr_flags i_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_grant     (wr_grant),
        .store_start  (store_start),
        .recall_start (recall_start),
        .pup_start    (pup_start),
        .auto_cmd     (auto_cmd),
        .auto_val     (auto_val),
        .dirty        (dirty),
        .autostore_en (autostore_en)
    );

    assign arr_phase = phase;

    // R8: no host access while the array is being worked on
    assert_no_access_in_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_NONE) |-> (!wr_grant && !rd_grant));

    // R12: the written flag is already clear when a store or recall step begins
    assert_dirty_clear_in_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ERASE || phase == PH_CLEAR) |-> !dirty);

    // R6: a store never runs alongside a granted write
    assert_busy_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_pull |-> !wr_grant);

endmodule

// File: tb/test_nvsr_seq.sv
module test_nvsr_seq;

    localparam int STC = 8;
    localparam int SRC = 6;
    localparam int PRC = 10;
    localparam int GRC = 3;

    logic       clk = 1'b0;
    logic       rst_n, pwr_good, ext_pull, sw_cmd_valid, host_ce_n, host_we_n;
    logic [1:0] sw_cmd_kind;
    logic       hwreq_n_in, busy_pull, wr_grant, rd_grant, autostore_en, dirty;
    logic [2:0] arr_phase;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    assign hwreq_n_in = !(ext_pull || busy_pull);

    nvsr_seq #(
        .STORE_CYC(STC), .SW_RECALL_CYC(SRC), .PUP_RECALL_CYC(PRC), .GRACE_CYC(GRC)
    ) i_nvsr_seq (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .hwreq_n_in(hwreq_n_in),
        .busy_pull(busy_pull), .sw_cmd_valid(sw_cmd_valid), .sw_cmd_kind(sw_cmd_kind),
        .host_ce_n(host_ce_n), .host_we_n(host_we_n), .wr_grant(wr_grant),
        .rd_grant(rd_grant), .arr_phase(arr_phase), .autostore_en(autostore_en), .dirty(dirty)
    );

    typedef struct packed {
        logic       wr;
        logic [1:0] cmd;
        logic [2:0] ph1;
        logic       busy1;
        logic [3:0] off2;
        logic [2:0] ph2;
        logic [3:0] settle;
        logic       dirty_after;
        logic       auto_after;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{wr:1'b1, cmd:2'b00, ph1:3'd1, busy1:1'b1, off2:4'd4, ph2:3'd2, settle:4'd9, dirty_after:1'b0, auto_after:1'b1},
        '{wr:1'b0, cmd:2'b00, ph1:3'd1, busy1:1'b1, off2:4'd4, ph2:3'd2, settle:4'd9, dirty_after:1'b0, auto_after:1'b1},
        '{wr:1'b1, cmd:2'b01, ph1:3'd3, busy1:1'b0, off2:4'd3, ph2:3'd4, settle:4'd6, dirty_after:1'b0, auto_after:1'b1},
        '{wr:1'b0, cmd:2'b10, ph1:3'd0, busy1:1'b0, off2:4'd0, ph2:3'd0, settle:4'd0, dirty_after:1'b0, auto_after:1'b0},
        '{wr:1'b0, cmd:2'b11, ph1:3'd0, busy1:1'b0, off2:4'd0, ph2:3'd0, settle:4'd0, dirty_after:1'b0, auto_after:1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic do_write(input string req);
        host_ce_n = 1'b0; host_we_n = 1'b0; #1;
        chk(req, int'(wr_grant), 1);
        step(1);
        host_ce_n = 1'b1; host_we_n = 1'b1;
        chk(req, int'(dirty), 1);
    endtask

    task automatic issue(input logic [1:0] k);
        sw_cmd_valid = 1'b1; sw_cmd_kind = k;
        step(1);
        sw_cmd_valid = 1'b0;
    endtask

    task automatic try_read(input string req, input int exp);
        host_ce_n = 1'b0; host_we_n = 1'b1; #1;
        chk(req, int'(rd_grant), exp);
        host_ce_n = 1'b1; #1;
    endtask

    task automatic try_write(input string req, input int exp);
        host_ce_n = 1'b0; host_we_n = 1'b0; #1;
        chk(req, int'(wr_grant), exp);
        host_ce_n = 1'b1; host_we_n = 1'b1; #1;
    endtask

    task automatic power_cycle_up;
        pwr_good = 1'b1;
        step(1 + PRC);
    endtask

    function automatic string tag_of(input logic [1:0] c);
        if (c == 2'b00) return "R4 sw store";
        if (c == 2'b01) return "R5 sw recall";
        return "R9 autostore cmd";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pwr_good = 1'b0; ext_pull = 1'b0; sw_cmd_valid = 1'b0;
        sw_cmd_kind = 2'b00; host_ce_n = 1'b1; host_we_n = 1'b1;
        step(3);
        rst_n = 1'b1;
        step(2);

        // R1 reset state
        chk("R1 phase", int'(arr_phase), 0);
        chk("R1 busy", int'(busy_pull), 0);
        chk("R1 autostore", int'(autostore_en), 1);
        chk("R1 dirty", int'(dirty), 0);
        try_read("R1 read blocked", 0);

        // R2 power-up recall with R10 write held at its end
        pwr_good = 1'b1;
        step(1);
        chk("R2 clear phase", int'(arr_phase), 3);
        try_read("R2 read blocked during recall", 0);
        step(4);
        chk("R2 clear last", int'(arr_phase), 3);
        step(1);
        chk("R2 load phase", int'(arr_phase), 4);
        host_ce_n = 1'b0; host_we_n = 1'b0;
        step(4);
        chk("R2 load last", int'(arr_phase), 4);
        step(1);
        chk("R2 idle", int'(arr_phase), 0);
        chk("R10 held write", int'(wr_grant), 0);
        host_we_n = 1'b1; #1;
        chk("R3 read grant", int'(rd_grant), 1);
        step(1);
        host_we_n = 1'b0; #1;
        chk("R10 fresh write", int'(wr_grant), 1);
        step(1);
        host_ce_n = 1'b1; host_we_n = 1'b1;
        chk("R3 dirty set", int'(dirty), 1);

        // table of software commands (R4 R5 R9 R12)
        for (int i = 0; i < 5; i++) begin
            if (VEC[i].wr) do_write("R3 write before cmd");
            issue(VEC[i].cmd);
            chk(tag_of(VEC[i].cmd), int'(arr_phase), int'(VEC[i].ph1));
            chk(tag_of(VEC[i].cmd), int'(busy_pull), int'(VEC[i].busy1));
            if (VEC[i].cmd[1] == 1'b0) chk("R12 dirty at start", int'(dirty), 0);
            if (VEC[i].off2 != 0) begin
                step(int'(VEC[i].off2));
                chk(tag_of(VEC[i].cmd), int'(arr_phase), int'(VEC[i].ph2));
                step(int'(VEC[i].settle) - int'(VEC[i].off2));
            end
            chk(tag_of(VEC[i].cmd), int'(arr_phase), 0);
            chk(tag_of(VEC[i].cmd), int'(busy_pull), 0);
            chk("R12 dirty after", int'(dirty), int'(VEC[i].dirty_after));
            chk("R9 autostore bit", int'(autostore_en), int'(VEC[i].auto_after));
            try_read("R3 read in idle", 1);
        end

        // R6 pin request without writes: no store, wait in HOLD
        ext_pull = 1'b1;
        step(1);
        try_read("R6 read in grace", 1);
        step(3);
        chk("R6 no store phase", int'(arr_phase), 0);
        chk("R6 no store busy", int'(busy_pull), 0);
        step(2);
        try_write("R7 write blocked while pin low", 0);
        ext_pull = 1'b0;
        step(1);
        try_read("R7 idle after pin high", 1);

        // R6/R7 pin request with a write pending
        do_write("R3 write before pin");
        ext_pull = 1'b1;
        step(1);
        try_read("R6 read in grace", 1);
        try_write("R6 write blocked in grace", 0);
        chk("R6 grace no phase", int'(arr_phase), 0);
        step(3);
        chk("R6 erase", int'(arr_phase), 1);
        chk("R6 busy", int'(busy_pull), 1);
        step(4);
        chk("R6 program", int'(arr_phase), 2);
        step(4);
        chk("R7 hold phase", int'(arr_phase), 0);
        chk("R7 hold busy", int'(busy_pull), 0);
        step(2);
        try_write("R7 write blocked in hold", 0);
        ext_pull = 1'b0;
        step(1);
        do_write("R7 write after pin high");

        // R8 supply loss with dirty and autostore enabled
        pwr_good = 1'b0; #1;
        try_read("R8 read blocked supply low", 0);
        step(1);
        chk("R8 autostore erase", int'(arr_phase), 1);
        step(4);
        chk("R8 autostore program", int'(arr_phase), 2);
        step(4);
        chk("R8 off after store", int'(arr_phase), 0);
        chk("R8 busy released", int'(busy_pull), 0);
        step(3);
        chk("R8 stays off", int'(arr_phase), 0);
        pwr_good = 1'b1;
        step(1);
        chk("R2 recall after brownout", int'(arr_phase), 3);
        step(PRC);
        chk("R2 idle again", int'(arr_phase), 0);

        // R8 supply loss with nothing written: straight to OFF
        pwr_good = 1'b0;
        step(1);
        chk("R8 no store clean", int'(arr_phase), 0);
        chk("R8 no busy clean", int'(busy_pull), 0);
        step(5);
        chk("R8 still off", int'(arr_phase), 0);
        power_cycle_up();

        // R9 persistence of the autostore bit
        issue(2'b10);
        chk("R9 disabled", int'(autostore_en), 0);
        issue(2'b00);
        step(9);
        pwr_good = 1'b0;
        step(2);
        power_cycle_up();
        chk("R9 saved disable kept", int'(autostore_en), 0);
        do_write("R3 write with autostore off");
        pwr_good = 1'b0;
        step(1);
        chk("R8 disabled no store", int'(arr_phase), 0);
        step(2);
        power_cycle_up();
        issue(2'b11);
        chk("R9 enabled volatile", int'(autostore_en), 1);
        pwr_good = 1'b0;
        step(2);
        power_cycle_up();
        chk("R9 unsaved enable lost", int'(autostore_en), 0);

        // R11 priority: supply loss beats pin and command
        issue(2'b11);
        do_write("R3 write before race");
        ext_pull = 1'b1; sw_cmd_valid = 1'b1; sw_cmd_kind = 2'b01; pwr_good = 1'b0;
        step(1);
        sw_cmd_valid = 1'b0; ext_pull = 1'b0;
        chk("R11 supply loss wins", int'(arr_phase), 1);
        step(8);
        chk("R11 off after store", int'(arr_phase), 0);
        power_cycle_up();

        // R11 pin beats software recall
        ext_pull = 1'b1; sw_cmd_valid = 1'b1; sw_cmd_kind = 2'b01;
        step(1);
        sw_cmd_valid = 1'b0;
        chk("R11 pin beats recall", int'(arr_phase), 0);
        try_read("R11 grace reads", 1);
        ext_pull = 1'b0;
        step(5);
        chk("R11 no recall later", int'(arr_phase), 0);

        // R11 command during a store is dropped
        issue(2'b00);
        chk("R11 store running", int'(arr_phase), 1);
        issue(2'b01);
        step(7);
        chk("R11 hold no recall", int'(arr_phase), 0);
        step(2);
        chk("R11 dropped recall", int'(arr_phase), 0);
        try_read("R11 idle read", 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule